// File: doc/BRIEF.md
# CRC Calculator with APB Register Front End

This block is an APB slave with a small CRC engine behind it. Software sets a control word, an initial value and an output XOR mask. It then writes message words to a data register. Each data write, while the engine is enabled, feeds one to four bytes into a running CRC held inside the block, at one byte per clock. A status bit shows when those bytes have been absorbed. A read of the data register returns the current CRC, after optional bit reflection and the XOR mask.

Four polynomials are offered, from an 8-bit code to a 32-bit code. The running CRC carries over from one data write to the next, so a message of any length is sent as a series of words. The CRC is loaded from the initial-value register only when the enable bit goes from 0 to 1.

Top module: `crc_apb_regs`

## Requirements
- R1: After reset, every mapped register reads zero, including DONE.
- R2: The map is CTRL 0x00, INIT 0x04, XORV 0x08, DATA 0x0C, STAT 0x10. CTRL holds EN in bit 0, REVIN in bit 1, REVOUT in bit 2, MODE in bits 4:3 and SIZE in bits 6:5. CTRL bits 31:7 and STAT bits 31:1 read as zero and ignore writes. INIT and XORV keep all 32 bits.
- R3: PREADY is always 1. PSLVERR is 1 in the access phase of any transfer to an offset outside the map, including misaligned ones, and 0 for mapped offsets. Such a transfer changes no register, and a read of it returns zero.
- R4: A CTRL write that moves EN from 0 to 1 loads the running CRC with INIT, cut to the width of the newly written MODE.
- R5: MODE 0 selects 8-bit polynomial 0x07, MODE 1 selects 16-bit 0x1021, MODE 2 selects 16-bit 0x8005 and MODE 3 selects 32-bit 0x04C11DB7. The CRC is computed unreflected, most significant bit first.
- R6: A DATA write with EN=1 processes the low SIZE+1 bytes of the written word, the most significant of those bytes first, at one byte per clock. DONE goes to 0 at the write and to 1 on the edge that handles the last byte.
- R7: With REVIN=1, the bit order inside each input byte is reversed before the byte is processed.
- R8: A DATA read returns the running CRC, bit-reversed across the code width when REVOUT=1, XORed with XORV, and cut to the code width. Upper bits read as zero.
- R9: The running CRC carries across DATA writes without being reloaded.
- R10: A DATA write while EN=0 starts nothing. DONE stays 0 and the result does not change.
- R11: A DATA write that arrives while bytes from an earlier write are still being processed is ignored.
- R12: Writing EN=0 clears DONE and stops any calculation that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | AW (5) | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Error for unmapped offsets |

## Verification
The bench checks standard check values for the string "123456789" in all four modes. These catch a wrong polynomial, a wrong byte order within a word, an input reflection applied to the whole word instead of to each byte, and a result that is not cut to the code width. It reads STAT at once after 1-byte and 4-byte writes, which would show up an engine that handles a whole word in one cycle. It also issues a second DATA write back-to-back with the first. A design that restarted on that write would return the CRC of the wrong bytes. It writes DATA while the engine is disabled and turns EN off after a finished run. A design that still computed in that state would change the result, and one that kept DONE set would report a stale completion. Finally it accesses unmapped and misaligned offsets and checks for the error response and zero read data.

// File: rtl/crc_apb_regs.sv
module crc_apb_regs #(
  parameter int AW = 5
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          pready,
  output logic          pslverr
);
  localparam logic [AW-1:0] A_CTRL = AW'(5'h00);
  localparam logic [AW-1:0] A_INIT = AW'(5'h04);
  localparam logic [AW-1:0] A_XORV = AW'(5'h08);
  localparam logic [AW-1:0] A_DATA = AW'(5'h0C);
  localparam logic [AW-1:0] A_STAT = AW'(5'h10);

  logic [6:0]  ctrl_q;
  logic [31:0] init_q, xorv_q, crc_q, sh_q;
  logic [1:0]  cnt_q;
  logic        busy_q, done_q;

  function automatic logic [31:0] wmask(input logic [1:0] m);
    case (m)
      2'd0:    return 32'h0000_00FF;
      2'd3:    return 32'hFFFF_FFFF;
      default: return 32'h0000_FFFF;
    endcase
  endfunction

  function automatic logic [4:0] wshift(input logic [1:0] m);
    case (m)
      2'd0:    return 5'd24;
      2'd3:    return 5'd0;
      default: return 5'd16;
    endcase
  endfunction

  function automatic logic [31:0] poly(input logic [1:0] m);
    case (m)
      2'd0:    return 32'h0000_0007;
      2'd1:    return 32'h0000_1021;
      2'd2:    return 32'h0000_8005;
      default: return 32'h04C1_1DB7;
    endcase
  endfunction

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b,
                                           input logic [1:0] m);
    logic [31:0] a, p;
    p = poly(m) << wshift(m);
    a = (c << wshift(m)) ^ {b, 24'h0};
    for (int i = 0; i < 8; i++) a = a[31] ? ((a << 1) ^ p) : (a << 1);
    return a >> wshift(m);
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  wire       en     = ctrl_q[0];
  wire       revin  = ctrl_q[1];
  wire       revout = ctrl_q[2];
  wire [1:0] mode   = ctrl_q[4:3];
  wire [1:0] size   = ctrl_q[6:5];

  wire hit_ctrl = paddr == A_CTRL;
  wire hit_init = paddr == A_INIT;
  wire hit_xorv = paddr == A_XORV;
  wire hit_data = paddr == A_DATA;
  wire hit_stat = paddr == A_STAT;
  wire mapped   = hit_ctrl | hit_init | hit_xorv | hit_data | hit_stat;
  wire acc      = psel & penable;
  wire wr       = acc & pwrite & mapped;

  wire [7:0]  cur_byte = 8'(sh_q >> {cnt_q, 3'b000});
  wire [7:0]  byte_in  = revin ? rev8(cur_byte) : cur_byte;
  wire [31:0] result   = ((revout ? (rev32(crc_q) >> wshift(mode)) : crc_q) ^ xorv_q)
                         & wmask(mode);

  assign pready  = 1'b1;
  assign pslverr = acc & ~mapped;

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (hit_ctrl)      prdata = {25'h0, ctrl_q};
      else if (hit_init) prdata = init_q;
      else if (hit_xorv) prdata = xorv_q;
      else if (hit_data) prdata = result;
      else if (hit_stat) prdata = {31'h0, done_q};
    end
  end

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      ctrl_q <= '0;
      init_q <= '0;
      xorv_q <= '0;
      crc_q  <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (wr && hit_init) init_q <= pwdata;
      if (wr && hit_xorv) xorv_q <= pwdata;
      if (busy_q) begin
        crc_q <= crc_step(crc_q, byte_in, mode);
        cnt_q <= cnt_q - 2'd1;
        if (cnt_q == 2'd0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (wr && hit_data && en) begin
        sh_q   <= pwdata;
        cnt_q  <= size;
        busy_q <= 1'b1;
        done_q <= 1'b0;
      end
      if (wr && hit_ctrl) begin
        ctrl_q <= pwdata[6:0];
        if (pwdata[0] && !en) crc_q <= init_q & wmask(pwdata[4:3]);
        if (!pwdata[0]) begin
          busy_q <= 1'b0;
          done_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/crc_apb_regs_chk.sv
module crc_apb_regs_chk #(
  parameter int AW = 5
) (
  input logic          pclk,
  input logic          presetn,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [31:0]   prdata,
  input logic          pready,
  input logic          pslverr,
  input logic          en,
  input logic          busy_q,
  input logic          done_q
);
  wire acc    = psel & penable;
  wire mapped = (paddr == AW'(5'h00)) || (paddr == AW'(5'h04)) || (paddr == AW'(5'h08)) ||
                (paddr == AW'(5'h0C)) || (paddr == AW'(5'h10));
  wire start  = acc & pwrite & (paddr == AW'(5'h0C)) & en & ~busy_q;

  AST_READY_HIGH: assert property (@(posedge pclk) disable iff (!presetn) pready); // R3
  AST_ERR_UNMAPPED: assert property (@(posedge pclk) disable iff (!presetn)
    acc && !mapped |-> pslverr && prdata == 32'h0); // R3
  AST_NO_ERR_MAPPED: assert property (@(posedge pclk) disable iff (!presetn)
    acc && mapped |-> !pslverr); // R3
  AST_CTRL_RSVD_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    psel && !pwrite && paddr == AW'(5'h00) |-> prdata[31:7] == 25'h0); // R2
  AST_STAT_RSVD_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    psel && !pwrite && paddr == AW'(5'h10) |-> prdata[31:1] == 31'h0); // R2
  AST_START_CLEARS_DONE: assert property (@(posedge pclk) disable iff (!presetn)
    start |=> busy_q && !done_q); // R6
  AST_DISABLED_IDLE: assert property (@(posedge pclk) disable iff (!presetn)
    !en |-> !busy_q && !done_q); // R12
  AST_DONE_EXCLUSIVE: assert property (@(posedge pclk) disable iff (!presetn)
    !(busy_q && done_q)); // R6
endmodule

bind crc_apb_regs crc_apb_regs_chk #(.AW(AW)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .pready(pready), .pslverr(pslverr),
  .en(ctrl_q[0]), .busy_q(busy_q), .done_q(done_q)
);

// File: tb/crc_apb_regs_bench.sv
module crc_apb_regs_bench;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  int          n_cmp = 0, n_bad = 0;
  logic        last_err;

  crc_apb_regs u_crc_apb_regs (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  always #4 pclk = ~pclk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1; #1 last_err = pslverr;
    @(posedge pclk);
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1; #1 d = prdata; last_err = pslverr;
    @(posedge pclk);
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge pclk);
  endtask

  function automatic logic [31:0] model_byte(input logic [31:0] c, input logic [7:0] b,
                                             input int w, input logic [31:0] p);
    logic [31:0] m;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
    c = c ^ ({24'h0, b} << (w - 8));
    for (int i = 0; i < 8; i++)
      c = c[w-1] ? (((c << 1) ^ p) & m) : ((c << 1) & m);
    return c;
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    for (int i = 0; i < 5; i++) begin
      apb_rd(5'(i * 4), d);
      check("R1 reset value", d, 0);
    end
  endtask

  task automatic t_regs;
    logic [31:0] d;
    apb_wr(5'h00, 32'hFFFF_FFFE); apb_rd(5'h00, d); check("R2 CTRL reserved bits", d, 32'h7E);
    apb_wr(5'h04, 32'hA5C3_1E0F); apb_rd(5'h04, d); check("R2 INIT rw", d, 32'hA5C3_1E0F);
    apb_wr(5'h08, 32'h5A3C_E1F0); apb_rd(5'h08, d); check("R2 XORV rw", d, 32'h5A3C_E1F0);
    apb_wr(5'h10, 32'hFFFF_FFFF); apb_rd(5'h10, d); check("R2 STAT read only", d, 0);
    check("R3 mapped no error", {31'h0, last_err}, 0);
    apb_wr(5'h00, 32'h0);
  endtask

  task automatic t_err;
    logic [31:0] d;
    apb_rd(5'h14, d);
    check("R3 unmapped error", {31'h0, last_err}, 1);
    check("R3 unmapped read zero", d, 0);
    apb_wr(5'h06, 32'hFFFF_FFFF);
    check("R3 misaligned error", {31'h0, last_err}, 1);
    check("R3 pready", {31'h0, pready}, 1);
    apb_rd(5'h04, d); check("R3 no side effect", d, 32'hA5C3_1E0F);
  endtask

  task automatic t_ccitt;
    logic [31:0] d;
    apb_wr(5'h04, 32'h1234_FFFF);
    apb_wr(5'h08, 32'h0);
    apb_wr(5'h00, 32'h69);
    apb_rd(5'h0C, d); check("R4 reload masked", d, 32'hFFFF);
    apb_wr(5'h0C, 32'h3132_3334);
    apb_rd(5'h10, d); check("R6 busy four bytes", d, 0);
    idle(4);
    apb_rd(5'h10, d); check("R6 done", d, 1);
    apb_wr(5'h0C, 32'h3536_3738); idle(6);
    apb_wr(5'h00, 32'h09);
    apb_wr(5'h0C, 32'h0000_0039); idle(3);
    apb_rd(5'h0C, d); check("R5 R9 mode1 check value", d, 32'h29B1);
  endtask

  task automatic t_crc8;
    logic [31:0] d;
    apb_wr(5'h00, 32'h0);
    apb_wr(5'h04, 32'h0);
    apb_wr(5'h00, 32'h01);
    for (int i = 0; i < 9; i++) begin
      apb_wr(5'h0C, 32'h31 + i);
      if (i == 0) begin apb_rd(5'h10, d); check("R6 single byte done", d, 1); end
    end
    idle(2);
    apb_rd(5'h0C, d); check("R5 mode0 check value", d, 32'hF4);
  endtask

  task automatic t_buypass;
    logic [31:0] d;
    apb_wr(5'h00, 32'h0);
    apb_wr(5'h04, 32'h0);
    apb_wr(5'h08, 32'hABCD_0000);
    apb_wr(5'h00, 32'h71);
    apb_wr(5'h0C, 32'h3132_3334); idle(6);
    apb_wr(5'h0C, 32'h3536_3738); idle(6);
    apb_wr(5'h00, 32'h11);
    apb_wr(5'h0C, 32'h0000_0039); idle(3);
    apb_rd(5'h0C, d); check("R5 R8 mode2 masked xor", d, 32'hFEE8);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    apb_wr(5'h00, 32'h10);
    apb_rd(5'h10, d); check("R12 done cleared", d, 0);
    apb_wr(5'h0C, 32'h1234_5678); idle(6);
    apb_rd(5'h10, d); check("R10 no start when disabled", d, 0);
    apb_rd(5'h0C, d); check("R10 result unchanged", d, 32'hFEE8);
  endtask

  task automatic t_refl32;
    logic [31:0] d;
    apb_wr(5'h00, 32'h0);
    apb_wr(5'h04, 32'hFFFF_FFFF);
    apb_wr(5'h08, 32'hFFFF_FFFF);
    apb_wr(5'h00, 32'h7F);
    apb_wr(5'h0C, 32'h3132_3334); idle(6);
    apb_wr(5'h0C, 32'h3536_3738); idle(6);
    apb_wr(5'h00, 32'h1F);
    apb_wr(5'h0C, 32'h0000_0039); idle(3);
    apb_rd(5'h0C, d); check("R7 R8 reflected mode3", d, 32'hCBF4_3926);
  endtask

  task automatic t_busy;
    logic [31:0] d, e;
    apb_wr(5'h00, 32'h0);
    apb_wr(5'h04, 32'h0);
    apb_wr(5'h08, 32'h0);
    apb_wr(5'h00, 32'h79);
    apb_wr(5'h0C, 32'h3132_3334);
    apb_wr(5'h0C, 32'hDEAD_BEEF);
    idle(8);
    e = 0;
    for (int i = 0; i < 4; i++) e = model_byte(e, 8'h31 + 8'(i), 32, 32'h04C1_1DB7);
    apb_rd(5'h0C, d); check("R11 write while busy ignored", d, e);
    apb_rd(5'h10, d); check("R11 done after first word", d, 1);
  endtask

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    t_reset();
    t_regs();
    t_err();
    t_ccitt();
    t_crc8();
    t_buypass();
    t_disable();
    t_refl32();
    t_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule